// File: doc/BRIEF.md
# Dual-Rail Return-to-Null Pipeline Register

This block is one stage register in a delay-insensitive pipeline whose data travels as dual-rail code. It is modelled synchronously on a single system clock. The register sits between two combinational stages. It watches the whole incoming word and changes its own output only when every bit position agrees. When every position carries a value, it takes a value wavefront. When every position is empty, it takes an empty (NULL) wavefront.

Value and empty wavefronts must alternate. The register takes a value word only while the downstream stage requests values (its acknowledge is high). It takes an empty word only after the downstream stage has withdrawn that request (its acknowledge is low). The acknowledge sent upstream is high while the register holds an empty word, which means it is ready for a value. It is low while a value is held. A full transfer therefore takes a value pass, an empty pass and two acknowledge trips before the next value can enter.

A forbidden rail pair anywhere on the input sets an error flag. The flag stays set until reset, and the register does not move while the forbidden pair is present.

Top module: `dr_hs_reg`

## Requirements
- R1: During and after reset, and before any wavefront is taken, `out_rails` is all zero, `ack_up` is 1 and `err_flag` is 0.
- R2: Bit i of a word travels on rails [2i+1:2i]. The pair 2'b01 is logic 0, 2'b10 is logic 1, 2'b00 is NULL and 2'b11 is forbidden.
- R3: While NULL is held, a word whose pairs are all 01 or 10 and that arrives with `ack_down`=1 appears unchanged on `out_rails` one clock later, and `ack_up` falls to 0 in that same cycle.
- R4: While NULL is held and `ack_down`=0, a complete value word is not taken. Output and `ack_up` stay as they are.
- R5: While a value is held, an all-NULL input with `ack_down`=0 clears `out_rails` to zero one clock later, and `ack_up` rises to 1 in that same cycle. With `ack_down`=1 the value is kept.
- R6: While a value is held, a different complete value word is ignored. A NULL word must come in between before new data is taken.
- R7: A partial word, with some pairs NULL and some pairs holding a value, changes neither `out_rails` nor `ack_up`.
- R8: Any 2'b11 pair on `in_rails` sets `err_flag` one clock later. The flag stays at 1 until reset, and the output does not change in a cycle whose input holds a forbidden pair.
- R9: `out_rails` never carries a 2'b11 pair. It is always either entirely NULL or entirely values, and `ack_up` is 1 exactly when it is entirely NULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_rails | input | 2*WIDTH | Dual-rail word from the upstream combinational stage |
| ack_down | input | 1 | Acknowledge from downstream; high requests a value, low requests NULL |
| out_rails | output | 2*WIDTH | Dual-rail word held for the downstream stage |
| ack_up | output | 1 | Acknowledge to upstream; high while NULL is held |
| err_flag | output | 1 | Sticky flag for a forbidden rail pair seen on the input |

## Verification
The hardest case to reach from the ports is an input that is complete but arrives in the wrong phase. One form is a fresh value word offered while a value is still held. The other is a complete NULL that comes with the downstream acknowledge still requesting values. In both cases a register that skips the return-to-NULL step would look correct on every ordinary transfer. The directed stimulus holds the input complete across several cycles while `ack_down` stays in each state in turn. It then follows with partial words, a forbidden pair and a long stretch of random wavefronts and acknowledges. A behavioural model in the bench predicts every output on every clock.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic {
        PH_NULL = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    localparam logic [1:0] RAIL_NULL = 2'b00;
    localparam logic [1:0] RAIL_ZERO = 2'b01;
    localparam logic [1:0] RAIL_ONE  = 2'b10;
    localparam logic [1:0] RAIL_BAD  = 2'b11;

endpackage

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int WIDTH = 8
) (
    input  logic [2*WIDTH-1:0] rails_i,
    output logic               all_data_o,
    output logic               all_null_o,
    output logic               any_bad_o
);
    import dr_pkg::*;

    logic [WIDTH-1:0] is_data;
    logic [WIDTH-1:0] is_null;
    logic [WIDTH-1:0] is_bad;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [1:0] pair;
        assign pair       = rails_i[2*b +: 2];
        assign is_data[b] = (pair == RAIL_ZERO) || (pair == RAIL_ONE);
        assign is_null[b] = (pair == RAIL_NULL);
        assign is_bad[b]  = (pair == RAIL_BAD);
    end

    assign all_data_o = &is_data;
    assign all_null_o = &is_null;
    assign any_bad_o  = |is_bad;

endmodule

// File: rtl/dr_phase_ctrl.sv
module dr_phase_ctrl (
    input  dr_pkg::phase_e phase_i,
    input  logic           all_data_i,
    input  logic           all_null_i,
    input  logic           any_bad_i,
    input  logic           ack_down_i,
    output logic           take_data_o,
    output logic           take_null_o
);
    import dr_pkg::*;

    always_comb begin
        take_data_o = 1'b0;
        take_null_o = 1'b0;
        if (!any_bad_i) begin
            unique case (phase_i)
                PH_NULL: take_data_o = all_data_i && ack_down_i;
                PH_DATA: take_null_o = all_null_i && !ack_down_i;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dr_hs_reg.sv
module dr_hs_reg #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] in_rails,
    input  logic               ack_down,
    output logic [2*WIDTH-1:0] out_rails,
    output logic               ack_up,
    output logic               err_flag
);
    import dr_pkg::*;

    localparam int RAILS = 2 * WIDTH;

    typedef struct packed {
        logic [RAILS-1:0] rails;
        phase_e           phase;
        logic             err;
    } state_t;

    state_t st_d, st_q;

    logic all_data, all_null, any_bad;
    logic take_data, take_null;

    dr_completion #(.WIDTH(WIDTH)) u_cmpl (
        .rails_i    (in_rails),
        .all_data_o (all_data),
        .all_null_o (all_null),
        .any_bad_o  (any_bad)
    );

    dr_phase_ctrl u_ctrl (
        .phase_i     (st_q.phase),
        .all_data_i  (all_data),
        .all_null_i  (all_null),
        .any_bad_i   (any_bad),
        .ack_down_i  (ack_down),
        .take_data_o (take_data),
        .take_null_o (take_null)
    );

    always_comb begin
        st_d = st_q;
        if (any_bad) begin
            st_d.err = 1'b1;
        end
        if (take_data) begin
            st_d.rails = in_rails;
            st_d.phase = PH_DATA;
        end else if (take_null) begin
            st_d.rails = '0;
            st_d.phase = PH_NULL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rails <= '0;
            st_q.phase <= PH_NULL;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_rails = st_q.rails;
    assign ack_up    = (st_q.phase == PH_NULL);
    assign err_flag  = st_q.err;

endmodule

// File: rtl/dr_hs_reg_chk.sv
module dr_hs_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*WIDTH-1:0] in_rails,
    input logic               ack_down,
    input logic [2*WIDTH-1:0] out_rails,
    input logic               ack_up,
    input logic               err_flag
);
    logic in_full, in_empty, in_bad;
    logic out_full, out_empty, out_bad;

    always_comb begin
        in_full = 1'b1; in_empty = 1'b1; in_bad = 1'b0;
        out_full = 1'b1; out_empty = 1'b1; out_bad = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            if (in_rails[2*k +: 2] == 2'b11) in_bad = 1'b1;
            if (in_rails[2*k] == in_rails[2*k+1]) in_full = 1'b0;
            if (in_rails[2*k +: 2] != 2'b00) in_empty = 1'b0;
            if (out_rails[2*k +: 2] == 2'b11) out_bad = 1'b1;
            if (out_rails[2*k] == out_rails[2*k+1]) out_full = 1'b0;
            if (out_rails[2*k +: 2] != 2'b00) out_empty = 1'b0;
        end
    end

    assert_out_coherent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_bad && (out_full || out_empty));

    assert_ack_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_up == out_empty);

    assert_capture_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_up && ack_down && in_full) |=> (out_rails == $past(in_rails)) && !ack_up);

    assert_no_take_wo_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_up && !ack_down) |=> $stable(out_rails));

    assert_capture_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_up && !ack_down && in_empty) |=> out_empty && ack_up);

    assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_up && !in_empty) |=> $stable(out_rails));

    assert_partial_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_full && !in_empty) |=> $stable(out_rails) && $stable(ack_up));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_bad |=> err_flag && $stable(out_rails));

endmodule

bind dr_hs_reg dr_hs_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_rails  (in_rails),
    .ack_down  (ack_down),
    .out_rails (out_rails),
    .ack_up    (ack_up),
    .err_flag  (err_flag)
);

// File: tb/test_dr_hs_reg.sv
module test_dr_hs_reg;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int R = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [R-1:0] in_rails = '0;
    logic         ack_down = 1'b0;
    logic [R-1:0] out_rails;
    logic         ack_up;
    logic         err_flag;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [R-1:0] m_out = '0;
    bit           m_data = 1'b0;
    bit           m_err = 1'b0;

    dr_hs_reg #(.WIDTH(W)) i_dr_hs_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_rails  (in_rails),
        .ack_down  (ack_down),
        .out_rails (out_rails),
        .ack_up    (ack_up),
        .err_flag  (err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [R-1:0] enc(input logic [W-1:0] v);
        logic [R-1:0] r;
        for (int i = 0; i < W; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    task automatic compare(input string tag);
        n_tests++;
        if (out_rails !== m_out || ack_up !== !m_data || err_flag !== m_err) begin
            n_fail++;
            $display("FAIL %s: actual out=%h ack=%b err=%b expected out=%h ack=%b err=%b",
                     tag, out_rails, ack_up, err_flag, m_out, !m_data, m_err);
        end
    endtask

    // drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input logic [R-1:0] in_v, input logic ack_v, input string tag);
        bit bad, full, empty;
        in_rails = in_v;
        ack_down = ack_v;
        bad = 0; full = 1; empty = 1;
        for (int i = 0; i < W; i++) begin
            if (in_v[2*i +: 2] == 2'b11) bad = 1;
            if (in_v[2*i +: 2] != 2'b01 && in_v[2*i +: 2] != 2'b10) full = 0;
            if (in_v[2*i +: 2] != 2'b00) empty = 0;
        end
        @(posedge clk);
        if (bad) m_err = 1;
        if (!m_data && full && ack_v) begin
            m_out = in_v;
            m_data = 1;
        end else if (m_data && empty && !ack_v) begin
            m_out = '0;
            m_data = 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [R-1:0] w;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        cyc(enc(8'hA5), 1'b1, "R3 capture A5");
        cyc(enc(8'h3C), 1'b1, "R6 new data ignored");
        cyc(enc(8'h00), 1'b1, "R6 zero data ignored");
        cyc('0, 1'b1, "R5 null with ack high kept");
        cyc('0, 1'b0, "R5 null taken");
        cyc(enc(8'hFF), 1'b0, "R4 data without request");
        cyc(enc(8'hFF), 1'b0, "R4 data without request again");
        cyc(enc(8'hFF), 1'b1, "R3 capture FF");
        cyc('0, 1'b0, "R5 null taken");

        w = enc(8'h5A); w[1:0] = 2'b00;
        cyc(w, 1'b1, "R7 partial from null");
        w = 16'h0002;
        cyc(w, 1'b1, "R7 single bit present");
        cyc(enc(8'h5A), 1'b1, "R2 capture 5A");
        w = '0; w[R-1 -: 2] = 2'b10;
        cyc(w, 1'b0, "R7 partial null while data held");
        cyc('0, 1'b0, "R5 null taken");

        w = enc(8'h81); w[5:4] = 2'b11;
        cyc(w, 1'b1, "R8 forbidden pair");
        cyc(enc(8'h81), 1'b1, "R8 flag sticky, capture");
        w = '0; w[3:2] = 2'b11;
        cyc(w, 1'b0, "R8 forbidden blocks null");
        cyc('0, 1'b0, "R8 flag stays");

        for (int n = 0; n < 400; n++) begin
            int sel = $urandom_range(0, 3);
            logic ack_r = 1'($urandom_range(0, 1));
            logic [R-1:0] v;
            if (sel == 0) v = '0;
            else if (sel == 1) v = enc(8'($urandom));
            else if (sel == 2) begin
                v = enc(8'($urandom));
                v[1:0] = 2'b00;
            end else v = enc(8'($urandom));
            cyc(v, ack_r, "R9 random wavefront");
        end

        rst_n = 1'b0;
        in_rails = '0;
        @(posedge clk);
        m_out = '0; m_data = 0; m_err = 0;
        @(negedge clk);
        compare("R1 second reset clears flag");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule